// File: doc/BRIEF.md
# Palette Pixel-Clock Divider and Byte-Latch Strobe Generator

This block sits between the display timing logic and an external palette/DAC. It runs on the pixel clock and produces three things. The first is the clock handed to the palette. The second is a one-cycle strobe that tells a multiplexing palette when to capture the first byte of a pixel. The third is a copy of the active-low blank signal, delayed as the selected palette needs.

The divide ratio depends on two inputs: the two-bit palette kind and the colour depth (standard, two bytes per pixel, or three bytes per pixel). A plain palette receives the pixel clock unchanged. A multiplexing palette receives it divided by the number of bytes per pixel. The block also reports the factor by which the horizontal CRT timing must be scaled, so that the timing generator can stretch its counts.

Configuration inputs are registered inside the block. Any change of palette kind or colour depth restarts the byte phase. The new setting takes effect from the first clock edge that samples it.

Top module: `pal_clk_gen`

## Requirements
- R1: While reset is asserted, latch_stb_o is 0, blank_n_o is 0 (blanking), hmult_o is 1 and dclk_o follows pix_clk_i.
- R2: With pal_type_i equal to 2'b00 or to 2'b11, dclk_o equals pix_clk_i in every colour mode and latch_stb_o stays 0.
- R3: With pal_type_i equal to 2'b01 or 2'b10 and neither hicolor_i nor truecolor_i set, dclk_o equals pix_clk_i and latch_stb_o stays 0.
- R4: With pal_type_i 2'b01 or 2'b10 and hicolor_i set, dclk_o repeats with a period of 2 pixel clocks: low in the phase-0 cycle, high in the phase-1 cycle.
- R5: With pal_type_i 2'b01 or 2'b10 and truecolor_i set, dclk_o repeats with a period of 3 pixel clocks: low in phase 0, high in phases 1 and 2.
- R6: In the divided modes of R4 and R5, latch_stb_o is high for exactly one pixel clock per divided period, in the phase-0 cycle. In all other modes it stays 0.
- R7: Any change of pal_type_i, hicolor_i or truecolor_i restarts the phase. The cycle after the edge that samples the new value is phase 0, including when the change lands on the last phase of a period.
- R8: When hicolor_i and truecolor_i are both set, the true-colour setting applies (ratio 3, multiplier 3).
- R9: hmult_o is 3 when truecolor_i is set, 2 when only hicolor_i is set and 1 otherwise, for every palette kind. It takes the new value in the cycle after the edge that samples the inputs.
- R10: For pal_type_i 2'b10, blank_n_o follows blank_n_i after 1 + N pixel clocks, where N is the active divide ratio (1, 2 or 3). For every other palette kind it follows after 1 pixel clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk_i | input | 1 | Incoming pixel clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| pal_type_i | input | 2 | Palette kind: 00 plain, 01 multiplexing, 10 multiplexing with delayed blank, 11 treated as 00 |
| hicolor_i | input | 1 | Two bytes per pixel colour mode |
| truecolor_i | input | 1 | Three bytes per pixel colour mode, wins over hicolor_i |
| blank_n_i | input | 1 | Active-low blank from the timing generator |
| dclk_o | output | 1 | Clock to the palette, direct or divided |
| latch_stb_o | output | 1 | Byte-latch strobe, one pixel clock wide at phase 0 |
| blank_n_o | output | 1 | Delayed active-low blank |
| hmult_o | output | 2 | Horizontal timing multiplier (1, 2 or 3) |

## Verification
The phase restart on a mode change and the natural wrap of the phase counter can fall in the same cycle. The bench provokes this by switching from true colour to hi-colour on the cycle where the counter sits on its last phase, so that either cause alone would send it to phase 0. It then checks that the strobe appears at once and that the following periods run at the new ratio rather than the old one. A second collision is a blank edge that arrives while the delayed-blank palette is active. Here the latency is measured against the divide ratio in force, for each of the three ratios.

// File: rtl/pal_clk_pkg.sv
package pal_clk_pkg;

  // Palette kind as seen on pal_type_i
  typedef enum logic [1:0] {
    PAL_PLAIN     = 2'b00,
    PAL_MUX       = 2'b01,
    PAL_MUX_BLDLY = 2'b10,
    PAL_SPARE     = 2'b11
  } pal_kind_e;

  // Registered configuration word; any change restarts the byte phase
  typedef struct packed {
    logic [1:0] kind;
    logic       hic;
    logic       tc;
  } pal_cfg_t;

  function automatic logic kind_is_muxed(input logic [1:0] k);
    return (k == PAL_MUX) || (k == PAL_MUX_BLDLY);
  endfunction

endpackage

// File: rtl/pal_mode_decode.sv
module pal_mode_decode
  import pal_clk_pkg::*;
#(
  parameter int HI_DIV = 2,
  parameter int TC_DIV = 3,
  localparam int DIV_W = $clog2(TC_DIV + 1)
) (
  input  pal_cfg_t         cfg_i,
  output logic [DIV_W-1:0] ratio_o,
  output logic [DIV_W-1:0] mult_o,
  output logic             strobe_en_o,
  output logic             blank_ext_o
);

  logic             muxed;
  logic [DIV_W-1:0] color_ratio;

  always_comb begin
    muxed = kind_is_muxed(cfg_i.kind);
    if (cfg_i.tc) begin
      color_ratio = DIV_W'(TC_DIV);
    end else if (cfg_i.hic) begin
      color_ratio = DIV_W'(HI_DIV);
    end else begin
      color_ratio = DIV_W'(1);
    end
    mult_o      = color_ratio;
    ratio_o     = muxed ? color_ratio : DIV_W'(1);
    strobe_en_o = muxed && (cfg_i.tc || cfg_i.hic);
    blank_ext_o = (cfg_i.kind == PAL_MUX_BLDLY);
  end

endmodule

// File: rtl/pal_phase_counter.sv
module pal_phase_counter
  import pal_clk_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  pal_cfg_t         cfg_i,
  input  logic [DIV_W-1:0] ratio_cur_i,
  output pal_cfg_t         cfg_q_o,
  output logic [DIV_W-1:0] phase_o
);

  pal_cfg_t         cfg_q;
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] phase_d;
  logic             cfg_chg;
  logic             wrap;

  // next-state
  always_comb begin
    cfg_chg = (cfg_i != cfg_q);
    wrap    = (phase_q >= (ratio_cur_i - DIV_W'(1)));
    if (cfg_chg || wrap) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + DIV_W'(1);
    end
  end

  // configuration register, loaded only on change
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cfg_q <= '0;
    end else if (cfg_chg) begin
      cfg_q <= cfg_i;
    end
  end

  // phase register
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign cfg_q_o = cfg_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/pal_blank_delay.sv
module pal_blank_delay #(
  parameter int DEPTH = 4,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             blank_n_i,
  input  logic [SEL_W-1:0] tap_i,
  output logic             blank_n_o
);

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q[0] <= 1'b0;
    end else begin
      stage_q[0] <= blank_n_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stage_q[g] <= 1'b0;
      end else begin
        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign blank_n_o = stage_q[tap_i];

endmodule

// File: rtl/pal_clk_gen.sv
module pal_clk_gen
  import pal_clk_pkg::*;
#(
  parameter int HI_DIV = 2,
  parameter int TC_DIV = 3,
  localparam int DIV_W = $clog2(TC_DIV + 1),
  localparam int DLY_DEPTH = TC_DIV + 1,
  localparam int TAP_W = $clog2(DLY_DEPTH)
) (
  input  logic             pix_clk_i,
  input  logic             rst_n_i,
  input  logic [1:0]       pal_type_i,
  input  logic             hicolor_i,
  input  logic             truecolor_i,
  input  logic             blank_n_i,
  output logic             dclk_o,
  output logic             latch_stb_o,
  output logic             blank_n_o,
  output logic [DIV_W-1:0] hmult_o
);

  pal_cfg_t         cfg_in;
  pal_cfg_t         cfg_q;
  logic [DIV_W-1:0] ratio_cur;
  logic [DIV_W-1:0] mult_cur;
  logic             strobe_en;
  logic             blank_ext;
  logic [DIV_W-1:0] phase;
  logic             bypass;
  logic             div_level;
  logic [TAP_W-1:0] tap;

  assign cfg_in = '{kind: pal_type_i, hic: hicolor_i, tc: truecolor_i};

  pal_mode_decode #(
    .HI_DIV (HI_DIV),
    .TC_DIV (TC_DIV)
  ) u_decode (
    .cfg_i       (cfg_q),
    .ratio_o     (ratio_cur),
    .mult_o      (mult_cur),
    .strobe_en_o (strobe_en),
    .blank_ext_o (blank_ext)
  );

  pal_phase_counter #(
    .DIV_W (DIV_W)
  ) u_phase (
    .clk_i       (pix_clk_i),
    .rst_n_i     (rst_n_i),
    .cfg_i       (cfg_in),
    .ratio_cur_i (ratio_cur),
    .cfg_q_o     (cfg_q),
    .phase_o     (phase)
  );

  pal_blank_delay #(
    .DEPTH (DLY_DEPTH)
  ) u_blank (
    .clk_i     (pix_clk_i),
    .rst_n_i   (rst_n_i),
    .blank_n_i (blank_n_i),
    .tap_i     (tap),
    .blank_n_o (blank_n_o)
  );

  always_comb begin
    bypass    = (ratio_cur == DIV_W'(1));
    div_level = (phase >= (ratio_cur >> 1));
    tap       = blank_ext ? TAP_W'(ratio_cur) : '0;
  end

  assign dclk_o      = bypass ? pix_clk_i : div_level;
  assign latch_stb_o = strobe_en && (phase == '0);
  assign hmult_o     = mult_cur;

endmodule

// File: rtl/pal_clk_gen_chk.sv
module pal_clk_gen_chk #(
  parameter int DIV_W  = 2,
  parameter int HI_DIV = 2,
  parameter int TC_DIV = 3
) (
  input logic             pix_clk_i,
  input logic             rst_n_i,
  input logic [1:0]       pal_type_i,
  input logic             hicolor_i,
  input logic             truecolor_i,
  input logic             blank_n_i,
  input logic             latch_stb_o,
  input logic             blank_n_o,
  input logic [DIV_W-1:0] hmult_o
);

  // R2: plain or spare palette never strobes
  assert_plain_no_strobe_R2: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    (pal_type_i == 2'b00 || pal_type_i == 2'b11) |=> !latch_stb_o);

  // R3: standard colour depth never strobes
  assert_std_no_strobe_R3: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    (!hicolor_i && !truecolor_i) |=> !latch_stb_o);

  // R6: in a steady mode the strobe lasts one pixel clock
  assert_strobe_single_R6: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    (latch_stb_o && $stable(pal_type_i) && $stable(hicolor_i) && $stable(truecolor_i))
      |=> !latch_stb_o);

  // R8 and R9: true colour selects the largest multiplier
  assert_tc_mult_R8: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    truecolor_i |=> (hmult_o == DIV_W'(TC_DIV)));

  // R9: hi-colour alone selects its multiplier
  assert_hic_mult_R9: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    (hicolor_i && !truecolor_i) |=> (hmult_o == DIV_W'(HI_DIV)));

  // R10: without the delayed-blank palette, blank lags by one cycle
  assert_blank_short_R10: assert property (@(posedge pix_clk_i) disable iff (!rst_n_i)
    (pal_type_i != 2'b10) |=> (blank_n_o == $past(blank_n_i)));

endmodule

bind pal_clk_gen pal_clk_gen_chk #(
  .DIV_W  (DIV_W),
  .HI_DIV (HI_DIV),
  .TC_DIV (TC_DIV)
) u_chk (
  .pix_clk_i   (pix_clk_i),
  .rst_n_i     (rst_n_i),
  .pal_type_i  (pal_type_i),
  .hicolor_i   (hicolor_i),
  .truecolor_i (truecolor_i),
  .blank_n_i   (blank_n_i),
  .latch_stb_o (latch_stb_o),
  .blank_n_o   (blank_n_o),
  .hmult_o     (hmult_o)
);

// File: tb/pal_clk_gen_tb.sv
module pal_clk_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] ptype;
  logic       hic;
  logic       tc;
  logic       blank_n;
  logic       dclk;
  logic       stb;
  logic       blank_n_out;
  logic [1:0] hmult;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pal_clk_gen dut_i (
    .pix_clk_i   (clk),
    .rst_n_i     (rst_n),
    .pal_type_i  (ptype),
    .hicolor_i   (hic),
    .truecolor_i (tc),
    .blank_n_i   (blank_n),
    .dclk_o      (dclk),
    .latch_stb_o (stb),
    .blank_n_o   (blank_n_out),
    .hmult_o     (hmult)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock edge, then sample 2 ns after it (clock is high here)
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mode(input logic [1:0] t, input logic h, input logic c);
    ptype = t;
    hic   = h;
    tc    = c;
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    blank_n = 1'b1;
    set_mode(2'b00, 1'b0, 1'b0);
    step();
    chk("R1 strobe", stb, 0);
    chk("R1 blank", blank_n_out, 0);
    chk("R1 hmult", hmult, 1);
    chk("R1 dclk high", dclk, 1);
    #4;
    chk("R1 dclk low", dclk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  // undivided palette clock: dclk follows the pixel clock, no strobe
  task automatic t_bypass(input string tag, input logic [1:0] t, input logic h, input logic c,
                          input int exp_mult);
    set_mode(t, h, c);
    step();
    step();
    chk({tag, " hmult R9"}, hmult, exp_mult);
    for (int i = 0; i < 3; i++) begin
      chk({tag, " dclk high"}, dclk, 1);
      chk({tag, " strobe"}, stb, 0);
      #4;
      chk({tag, " dclk low"}, dclk, 0);
      chk({tag, " strobe low phase"}, stb, 0);
      step();
    end
  endtask

  // divided palette clock, starting from a mode change
  task automatic t_divided(input string tag, input logic [1:0] t, input logic h, input logic c,
                           input int ratio);
    set_mode(t, h, c);
    step();
    for (int i = 0; i < 3 * ratio; i++) begin
      int ph;
      ph = i % ratio;
      chk({tag, " R6 strobe"}, stb, (ph == 0) ? 1 : 0);
      chk({tag, " dclk"}, dclk, (ph >= ratio / 2) ? 1 : 0);
      chk({tag, " R9 hmult"}, hmult, ratio);
      #4;
      chk({tag, " dclk steady"}, dclk, (ph >= ratio / 2) ? 1 : 0);
      step();
    end
  endtask

  // R7: change of mode on the last phase of a period, and change of kind only
  task automatic t_restart();
    set_mode(2'b01, 1'b0, 1'b1);
    step();
    chk("R7 tc start strobe", stb, 1);
    step();
    step();
    chk("R7 tc last phase strobe", stb, 0);
    chk("R7 tc last phase dclk", dclk, 1);
    set_mode(2'b01, 1'b1, 1'b0);
    step();
    chk("R7 restart strobe", stb, 1);
    chk("R7 restart dclk", dclk, 0);
    step();
    chk("R7 new ratio phase1 dclk", dclk, 1);
    chk("R7 new ratio phase1 strobe", stb, 0);
    step();
    chk("R7 new ratio wraps at 2", stb, 1);
    step();
    chk("R7 before kind change", stb, 0);
    set_mode(2'b10, 1'b1, 1'b0);
    step();
    chk("R7 kind change strobe", stb, 1);
    step();
    chk("R7 kind change phase1", stb, 0);
  endtask

  task automatic t_blank(input string tag, input logic [1:0] t, input logic h, input logic c,
                         input int exp_lat);
    int lat;
    set_mode(t, h, c);
    blank_n = 1'b1;
    for (int i = 0; i < 6; i++) step();
    chk({tag, " R10 idle high"}, blank_n_out, 1);
    blank_n = 1'b0;
    step();
    blank_n = 1'b1;
    lat = 0;
    for (int n = 1; n <= 6; n++) begin
      if (lat == 0 && blank_n_out == 1'b0) lat = n;
      if (n < 6) step();
    end
    chk({tag, " R10 latency"}, lat, exp_lat);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass("R2 type00 std", 2'b00, 1'b0, 1'b0, 1);
    t_bypass("R2 type00 tc", 2'b00, 1'b0, 1'b1, 3);
    t_bypass("R2 type11 hic", 2'b11, 1'b1, 1'b0, 2);
    t_bypass("R3 type01 std", 2'b01, 1'b0, 1'b0, 1);
    t_bypass("R3 type10 std", 2'b10, 1'b0, 1'b0, 1);
    t_divided("R4 type01 hic", 2'b01, 1'b1, 1'b0, 2);
    t_divided("R5 type10 tc", 2'b10, 1'b0, 1'b1, 3);
    t_divided("R8 type01 both", 2'b01, 1'b1, 1'b1, 3);
    t_restart();
    t_blank("type00 tc", 2'b00, 1'b0, 1'b1, 1);
    t_blank("type01 tc", 2'b01, 1'b0, 1'b1, 1);
    t_blank("type10 std", 2'b10, 1'b0, 1'b0, 2);
    t_blank("type10 hic", 2'b10, 1'b1, 1'b0, 3);
    t_blank("type10 tc", 2'b10, 1'b0, 1'b1, 4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule